// File: doc/BRIEF.md
# Single-Slot Serial Audio Transmitter

This block is the transmit half of a frame-based serial audio link in its simplest form: each frame carries one data word, placed in the first time slot. A frame holds a programmable number of slots, each a programmable number of bits long. Slots after the first carry no data and only stretch the frame. The bit clock comes from the system clock through a programmable divider, or from an external pin. In continuous-clock operation the bit clock runs all the time and a one-bit frame sync marks every frame boundary. In gated-clock operation there is no frame sync, and the bit clock only pulses while a word is being shifted out.

Words enter through a valid/ready stream. A word is accepted on a system-clock edge where `s_valid` and `s_ready` are both high. `s_ready` is the only back-pressure: it is low while the active store is full. The active store is either a single holding register or an 8-entry FIFO. The host may hold `s_valid` high, and the word and `s_valid` must stay unchanged until that edge. A word that cannot be accepted is never dropped. A transmit-request pin tells the host when it can add more. A missing word in continuous mode sends silence and raises a sticky underrun flag.

Top module: `sat_tx`

## Requirements
- R1: While `rst_n` is low, `bclk_o`, `fsync_o`, `sdata_o` and `urun_o` are 0, and with the FIFO off `s_ready` and `tx_req_o` are 1.
- R2: With the internal clock, `bclk_o` is a square wave of period 2*(`cfg_div`+1) system clocks. It first rises `cfg_div`+1 cycles after the transmitter starts running, and each bit period begins on its falling edge.
- R3: With `cfg_ext_clk`=1, the external clock passes through a two-flop synchronizer. `bclk_o` follows the pin three edges later, and a falling edge of the pin first sampled at edge k advances the serial outputs at edge k+2.
- R4: A frame lasts (`cfg_word_len`+1)*(`cfg_slots`+1) bit periods. After the transmitter starts, the first bit period is a lead-in carrying only the frame sync, and frames follow it back to back.
- R5: In continuous mode `fsync_o` is high for exactly one bit period: the last bit of each frame, which is the bit period just before the first data bit.
- R6: During slot 0, `sdata_o` carries bits `cfg_word_len` down to 0 of the current word, MSB first, one per bit period. Word bits above `cfg_word_len` are ignored, and `sdata_o` is 0 in all other slots. `cfg_word_len` must be at least 1.
- R7: With `cfg_fifo_en`=0 the store is one holding register, so `s_ready` is low while it holds a word. With `cfg_fifo_en`=1 the store is a first-in first-out queue of 8 words, so `s_ready` is low while 8 are held. Words go out in arrival order, and one is taken from the store at the start of each frame.
- R8: In continuous mode, if the store is empty at a frame start, the slot is sent as zeros and `urun_o` is set. `urun_o` stays set until a cycle with `urun_clr`=1. A new underrun in that same cycle wins.
- R9: With `cfg_gated`=1, `fsync_o` stays 0 and `urun_o` is never set. `bclk_o` toggles only during the data bits of a frame that loaded a word.
- R10: `tx_req_o` = 1 when the FIFO is on and the number of free entries is at least `cfg_wmark`, or when the FIFO is off and the holding register is empty.
- R11: While `cfg_en` or `cfg_tx_en` is 0, the bit clock, frame sync and data are held at 0 and the frame position resets, so the next run starts with the lead-in. Stored words and `urun_o` are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Block enable |
| cfg_tx_en | input | 1 | Transmitter enable |
| cfg_fifo_en | input | 1 | Select FIFO (1) or holding register (0) |
| cfg_gated | input | 1 | Gated-clock mode (1) or continuous (0) |
| cfg_ext_clk | input | 1 | Use external bit clock |
| cfg_div | input | DIV_W | Half bit period in system clocks, minus 1 |
| cfg_word_len | input | LEN_W | Bits per slot minus 1 |
| cfg_slots | input | SLOT_W | Slots per frame minus 1 |
| cfg_wmark | input | CNT_W | Free-entry watermark for the FIFO |
| ext_bclk | input | 1 | External bit clock |
| s_valid | input | 1 | Transmit word valid |
| s_data | input | DATA_W | Transmit word |
| s_ready | output | 1 | Store can accept a word |
| urun_clr | input | 1 | Clear the underrun flag |
| bclk_o | output | 1 | Serial bit clock |
| fsync_o | output | 1 | Frame sync |
| sdata_o | output | 1 | Serial data |
| urun_o | output | 1 | Sticky underrun flag |
| tx_req_o | output | 1 | Transmit request |

## Verification
The bench uses the default parameters: 32-bit words, an 8-entry FIFO, an 8-bit divider, 4-bit slot count. At run time it programs divider values 0, 1 and 2, word lengths of 5, 8, 16 and 4 bits, and one to three slots per frame. That covers a single-slot frame where the sync overlaps the last data bit, a multi-slot frame where idle slots follow the word, and the full and near-full FIFO levels that drive back-pressure and the watermark. A slow external clock is also run, which brings the synchronizer latency into view.

// File: rtl/sat_pkg.sv
package sat_pkg;
  // frame-sequencer events handed to the shifter
  typedef struct packed {
    logic load;   // first bit of slot 0
    logic shift;  // later bit of slot 0
    logic idle;   // lead-in or a non-data slot
  } sat_ev_t;

  typedef enum logic {
    SRC_DIVIDER = 1'b0,
    SRC_PIN     = 1'b1
  } sat_clk_src_e;
endpackage

// File: rtl/sat_bitclk.sv
module sat_bitclk #(
  parameter int DIV_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  sat_pkg::sat_clk_src_e src,
  input  logic [DIV_W-1:0] div,
  input  logic             ext_bclk,
  output logic             tick,
  output logic             lvl
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [DIV_W-1:0] cnt;
  logic             phase;
  logic [SH_W-1:0]  sync;
  logic             int_tick, ext_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
      sync  <= '0;
    end else begin
      sync <= {sync[SH_W-2:0], ext_bclk};
      if (!run) begin
        cnt   <= '0;
        phase <= 1'b0;
      end else if (cnt == div) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // a bit period starts on the falling edge of the chosen clock
  assign int_tick = run && phase && (cnt == div);
  assign ext_tick = run && !sync[SH_W-2] && sync[SH_W-1];

  always_comb begin
    if (src == sat_pkg::SRC_PIN) begin
      tick = ext_tick;
      lvl  = sync[SH_W-1];
    end else begin
      tick = int_tick;
      lvl  = phase;
    end
  end
endmodule

// File: rtl/sat_fifo.sv
module sat_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sat_framer.sv
module sat_framer #(
  parameter int LEN_W = 5,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              cont,
  input  logic [LEN_W-1:0]  word_len,
  input  logic [SLOT_W-1:0] slots,
  output sat_pkg::sat_ev_t  ev,
  output logic              fsync
);
  logic [LEN_W-1:0]  bit_q, nbit;
  logic [SLOT_W-1:0] slot_q, nslot;
  logic              started;
  logic              last_bit, last_slot;

  assign last_bit  = (bit_q == word_len);
  assign last_slot = (slot_q == slots);
  assign nbit      = last_bit ? '0 : bit_q + 1'b1;
  assign nslot     = last_bit ? (last_slot ? '0 : slot_q + 1'b1) : slot_q;

  always_comb begin
    ev.load  = tick && started && (nslot == '0) && (nbit == '0);
    ev.shift = tick && started && (nslot == '0) && (nbit != '0);
    ev.idle  = tick && (!started || (nslot != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      slot_q  <= '0;
      started <= 1'b0;
      fsync   <= 1'b0;
    end else if (!run) begin
      bit_q   <= '0;
      slot_q  <= '0;
      started <= 1'b0;
      fsync   <= 1'b0;
    end else if (tick) begin
      if (!started) begin
        // lead-in: park on the final bit so the sync precedes frame 0
        started <= 1'b1;
        bit_q   <= word_len;
        slot_q  <= slots;
        fsync   <= cont;
      end else begin
        bit_q  <= nbit;
        slot_q <= nslot;
        fsync  <= cont && (nbit == word_len) && (nslot == slots);
      end
    end
  end
endmodule

// File: rtl/sat_shifter.sv
module sat_shifter #(
  parameter int DATA_W = 32,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  sat_pkg::sat_ev_t  ev,
  input  logic              avail,
  input  logic [DATA_W-1:0] word,
  input  logic [LEN_W-1:0]  word_len,
  output logic              sdata,
  output logic              active
);
  localparam logic [LEN_W-1:0] TOP = LEN_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh;
  logic [LEN_W-1:0]  align;

  assign align = TOP - word_len;
  assign sdata = active && sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      active <= 1'b0;
    end else if (!run) begin
      sh     <= '0;
      active <= 1'b0;
    end else if (ev.load) begin
      active <= avail;
      sh     <= avail ? (word << align) : '0;
    end else if (ev.shift) begin
      sh <= sh << 1;
    end else if (ev.idle) begin
      active <= 1'b0;
    end
  end
endmodule

// File: rtl/sat_tx.sv
module sat_tx #(
  parameter int DATA_W = 32,
  parameter int DIV_W = 8,
  parameter int SLOT_W = 4,
  parameter int FIFO_DEPTH = 8,
  localparam int LEN_W = $clog2(DATA_W),
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_tx_en,
  input  logic              cfg_fifo_en,
  input  logic              cfg_gated,
  input  logic              cfg_ext_clk,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LEN_W-1:0]  cfg_word_len,
  input  logic [SLOT_W-1:0] cfg_slots,
  input  logic [CNT_W-1:0]  cfg_wmark,
  input  logic              ext_bclk,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  input  logic              urun_clr,
  output logic              bclk_o,
  output logic              fsync_o,
  output logic              sdata_o,
  output logic              urun_o,
  output logic              tx_req_o
);
  import sat_pkg::*;

  logic              run, tick, lvl, active;
  sat_ev_t           ev;
  sat_clk_src_e      src;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data, fifo_rdata, word;
  logic [CNT_W-1:0]  fifo_count, fifo_free;
  logic              fifo_full, fifo_empty, fifo_push, fifo_pop;
  logic              avail, accept, urun_set;

  assign run = cfg_en && cfg_tx_en;
  assign src = cfg_ext_clk ? SRC_PIN : SRC_DIVIDER;

  sat_bitclk #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .src(src), .div(cfg_div),
    .ext_bclk(ext_bclk), .tick(tick), .lvl(lvl)
  );

  sat_framer #(.LEN_W(LEN_W), .SLOT_W(SLOT_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cont(!cfg_gated),
    .word_len(cfg_word_len), .slots(cfg_slots), .ev(ev), .fsync(fsync_o)
  );

  // word store: single holding register or the queue
  assign s_ready   = cfg_fifo_en ? !fifo_full : !hold_full;
  assign accept    = s_valid && s_ready;
  assign avail     = cfg_fifo_en ? !fifo_empty : hold_full;
  assign word      = cfg_fifo_en ? fifo_rdata : hold_data;
  assign fifo_push = accept && cfg_fifo_en;
  assign fifo_pop  = ev.load && cfg_fifo_en;

  sat_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(s_data), .pop(fifo_pop),
    .rdata(fifo_rdata), .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (accept && !cfg_fifo_en) begin
      hold_full <= 1'b1;
      hold_data <= s_data;
    end else if (ev.load && !cfg_fifo_en) begin
      hold_full <= 1'b0;
    end
  end

  sat_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .run(run), .ev(ev), .avail(avail), .word(word),
    .word_len(cfg_word_len), .sdata(sdata_o), .active(active)
  );

  // underrun: only a running continuous clock can miss a word
  assign urun_set = ev.load && !avail && !cfg_gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        urun_o <= 1'b0;
    else if (urun_set) urun_o <= 1'b1;
    else if (urun_clr) urun_o <= 1'b0;
  end

  assign fifo_free = CNT_W'(FIFO_DEPTH) - fifo_count;
  assign tx_req_o  = cfg_fifo_en ? (fifo_free >= cfg_wmark) : !hold_full;
  assign bclk_o    = run && lvl && (!cfg_gated || active);
endmodule

// File: rtl/sat_tx_chk.sv
module sat_tx_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_gated,
  input logic          cfg_fifo_en,
  input logic          run,
  input logic          tick,
  input logic          s_valid,
  input logic          s_ready,
  input logic [CW-1:0] fifo_cnt,
  input logic          urun_o,
  input logic          urun_clr,
  input logic          fsync_o,
  input logic          sdata_o
);
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fifo_en && s_valid && s_ready |-> fifo_cnt < CW'(DEPTH));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    urun_o && !urun_clr |=> urun_o);

  a_r9_no_sync_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_gated && !fsync_o |=> !fsync_o);

  a_r9_no_underrun_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_gated |=> !$rose(urun_o));

  a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !fsync_o && !sdata_o);

  a_r6_hold_between_bits: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick |=> $stable(sdata_o) && $stable(fsync_o));
endmodule

bind sat_tx sat_tx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_gated(cfg_gated), .cfg_fifo_en(cfg_fifo_en),
  .run(run), .tick(tick), .s_valid(s_valid), .s_ready(s_ready),
  .fifo_cnt(fifo_count), .urun_o(urun_o), .urun_clr(urun_clr),
  .fsync_o(fsync_o), .sdata_o(sdata_o)
);

// File: tb/sat_tx_test.sv
module sat_tx_test;
  logic        clk = 0, rst_n = 0;
  logic        cfg_en = 0, cfg_tx_en = 0, cfg_fifo_en = 0, cfg_gated = 0, cfg_ext_clk = 0;
  logic [7:0]  cfg_div = 0;
  logic [4:0]  cfg_word_len = 1;
  logic [3:0]  cfg_slots = 0, cfg_wmark = 0;
  logic        ext_bclk = 0, s_valid = 0, urun_clr = 0;
  logic [31:0] s_data = 0;
  logic        s_ready, bclk_o, fsync_o, sdata_o, urun_o, tx_req_o;

  sat_tx uut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int unsigned mq[$];
  int t = 0, b = 0, j = 0;
  bit act = 0, ind = 0, efs = 0, esd = 0, eur = 0;
  bit h1 = 0, h2 = 0, h3 = 0;
  int unsigned cur = 0;
  int last_rise = 0, spacing = 0;
  bit prev_fs = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mq.delete(); t = 0; b = 0; act = 0; ind = 0; efs = 0; esd = 0; eur = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      bit run_m, step, rdy, set;
      int cap, per, wl, fl, lvl, free;
      run_m = cfg_en && cfg_tx_en;
      cap   = cfg_fifo_en ? 8 : 1;
      rdy   = mq.size() < cap;
      per   = 2 * (int'(cfg_div) + 1);
      wl    = int'(cfg_word_len);
      fl    = (wl + 1) * (int'(cfg_slots) + 1);
      set   = 0;
      if (cfg_ext_clk) step = run_m && !h2 && h3;
      else             step = run_m && ((t + 1) % per == 0);
      h3 = h2; h2 = h1; h1 = ext_bclk;
      if (run_m) t++;
      else begin t = 0; b = 0; act = 0; ind = 0; efs = 0; esd = 0; end
      if (step) begin
        b++;
        if (b == 1) begin
          efs = !cfg_gated; esd = 0; ind = 0; act = 0;
        end else begin
          j = (b - 2) % fl;
          if (j == 0) begin
            act = 0;
            if (mq.size() > 0) begin cur = mq.pop_front(); act = 1; end
            else if (!cfg_gated) begin eur = 1; set = 1; end
          end
          ind = act && (j <= wl);
          esd = ind ? cur[wl - j] : 1'b0;
          efs = !cfg_gated && (j == fl - 1);
        end
      end
      if (urun_clr && !set) eur = 0;
      if (s_valid && rdy) mq.push_back(s_data);
      free = 8 - mq.size();
      #2;
      lvl = cfg_ext_clk ? int'(h3) : ((t / (int'(cfg_div) + 1)) % 2);
      chk(cfg_ext_clk ? "R3" : (cfg_gated ? "R9" : "R2"), "bclk_o", int'(bclk_o),
          int'(run_m && lvl == 1 && (!cfg_gated || ind)));
      chk("R5 R4", "fsync_o", int'(fsync_o), int'(efs));
      chk("R6", "sdata_o", int'(sdata_o), int'(esd));
      chk("R7", "s_ready", int'(s_ready), int'(mq.size() < cap));
      chk("R8", "urun_o", int'(urun_o), int'(eur));
      chk("R10", "tx_req_o", int'(tx_req_o),
          int'(cfg_fifo_en ? (free >= int'(cfg_wmark)) : (mq.size() == 0)));
      if (fsync_o && !prev_fs) begin spacing = cyc - last_rise; last_rise = cyc; end
      prev_fs = fsync_o;
    end
  end

  // ---------------- external clock source ----------------
  bit ext_on = 0;
  int ecnt = 0;
  always @(negedge clk) begin
    if (ext_on) begin
      ecnt++;
      if (ecnt == 5) begin ecnt = 0; ext_bclk = ~ext_bclk; end
    end
  end

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1; s_data = d;
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_run;
    @(negedge clk); cfg_tx_en = 0; cfg_en = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    idle(3);
    chk("R1", "reset bclk", int'(bclk_o), 0);
    chk("R1", "reset fsync", int'(fsync_o), 0);
    chk("R1", "reset sdata", int'(sdata_o), 0);
    chk("R1", "reset urun", int'(urun_o), 0);
    chk("R1", "reset ready", int'(s_ready), 1);
    chk("R1", "reset req", int'(tx_req_o), 1);
    rst_n = 1;
    idle(2);

    // continuous, holding register, 3 slots of 8 bits, bit period 4
    cfg_div = 1; cfg_word_len = 7; cfg_slots = 2;
    push(32'h0000_00A5);
    @(negedge clk); cfg_en = 1; cfg_tx_en = 1;
    push(32'hFFFF_FF3C);
    push(32'h0000_0081);
    idle(400);
    chk("R4", "frame spacing", spacing, 96);
    chk("R8", "underrun after drain", int'(urun_o), 1);
    stop_run;
    idle(3);
    chk("R11", "bclk off", int'(bclk_o), 0);
    chk("R11", "flag kept", int'(urun_o), 1);
    urun_clr = 1; @(negedge clk); urun_clr = 0;
    idle(1);
    chk("R8", "flag cleared", int'(urun_o), 0);

    // FIFO, one 16-bit slot, bit period 2, watermark 3
    cfg_fifo_en = 1; cfg_wmark = 3; cfg_div = 0; cfg_word_len = 15; cfg_slots = 0;
    for (int i = 0; i < 8; i++) push(32'h1234_0000 + 32'(i * 4099));
    idle(1);
    chk("R7", "ready low when 8 held", int'(s_ready), 0);
    chk("R10", "req low when full", int'(tx_req_o), 0);
    @(negedge clk); cfg_en = 1; cfg_tx_en = 1;
    push(32'h0000_BEEF);
    push(32'h0000_7001);
    idle(420);
    stop_run;
    urun_clr = 1; @(negedge clk); urun_clr = 0;

    // gated clock, holding register, 2 slots of 4 bits
    cfg_fifo_en = 0; cfg_gated = 1; cfg_div = 2; cfg_word_len = 3; cfg_slots = 1;
    push(32'h0000_000B);
    idle(2);
    chk("R11", "word kept while off", int'(s_ready), 0);
    @(negedge clk); cfg_en = 1; cfg_tx_en = 1;
    push(32'h0000_0006);
    idle(200);
    chk("R9", "no underrun gated", int'(urun_o), 0);
    stop_run;
    cfg_gated = 0;

    // external clock, FIFO, 2 slots of 5 bits
    cfg_fifo_en = 1; cfg_wmark = 1; cfg_ext_clk = 1; cfg_word_len = 4; cfg_slots = 1;
    ext_on = 1;
    push(32'h0000_0016); push(32'h0000_0009); push(32'h0000_001F);
    @(negedge clk); cfg_en = 1; cfg_tx_en = 1;
    idle(450);
    stop_run;
    ext_on = 0; ext_bclk = 0;
    idle(5);
    chk("R3", "ext run quiet", int'(sdata_o), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule